// File: doc/BRIEF.md
# Host Image FIFO with Burst Request

This block buffers image bytes between a pixel-side producer and a byte-wide host that pulls the data with single-cycle read strobes. The strobes are already synchronised to the block clock. The producer writes only while a frame envelope level is high. Each rising edge of that envelope starts a new image and empties the buffer.

The host learns that data is waiting in one of two ways. An interrupt line follows the fill level against a programmable threshold. A request line suits a DMA engine that moves fixed bursts of 8, 16 or 32 bytes. The request drops as soon as a burst begins, and it is evaluated again only once the whole burst has been read. This lets an edge-sensitive DMA controller see one edge per burst.

At the end of a frame the tail of the image may not reach the threshold. Both lines therefore stay asserted while any byte remains. A sticky error flag records bytes discarded at frame start and writes lost to a full buffer.

Top module: `img_host_fifo`

## Requirements
- R1: After reset the fill count is 0, the read byte is 0x00, the error flag and the interrupt are low, and the request pin sits at its inactive level.
- R2: While the envelope is high, each byte written is stored, and bytes leave in write order. The read byte shows the oldest stored byte in the cycle after a strobe, and the fill count tracks writes minus reads. Writes while the envelope is low are ignored.
- R3: A write while the count equals DEPTH (default 2048) is dropped and sets the error flag. The count never exceeds DEPTH.
- R4: A read strobe on an empty buffer leaves the count at 0 and the read byte at the last byte actually read.
- R5: In the cycle the envelope rises, the buffer is emptied and any read is ignored. A write in that cycle becomes the first byte of the new frame. The error flag is set if the count was nonzero.
- R6: The error flag stays set until err_clr is high at a clock edge. A new error in that same cycle wins over the clear.
- R7: The interrupt is high exactly when the count is at least cfg_thresh, or when the frame-done state holds and the count is nonzero. It falls once reads take the count below the threshold.
- R8: With no burst open, the request is active under the same condition as R7. A read strobe while the request is active opens a burst, and the request goes inactive in the next cycle.
- R9: cfg_burst selects the burst length: 0 gives 8 strobes, 1 gives 16, and 2 or 3 give 32. Every strobe in a burst counts, empty or not. After the last strobe the burst closes and the request shows the R8 condition again.
- R10: With cfg_drq_high = 1 the request pin is active high. With 0 it is active low.
- R11: A falling envelope sets the frame-done state, and the next rising envelope clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_env | input | 1 | Frame envelope level; high while an image is delivered |
| px_valid | input | 1 | Image byte present on px_data |
| px_data | input | 8 | Image byte from the producer |
| host_rd | input | 1 | Synchronised one-cycle host read strobe |
| err_clr | input | 1 | Clears the error flag |
| cfg_thresh | input | 16 | Fill threshold, 1 up to 2032 |
| cfg_burst | input | 2 | Burst length select |
| cfg_drq_high | input | 1 | Request pin polarity, 1 = active high |
| rd_byte | output | 8 | Byte returned by the latest read |
| fill_count | output | 16 | Bytes currently stored |
| err_flag | output | 1 | Sticky discard/overflow flag |
| irq | output | 1 | Interrupt request |
| drq | output | 1 | Burst DMA request |

## Verification
Directed sequences cover each of these cases:
- A short in-order transfer.
- Reads on an empty buffer, which tell a held byte apart from fresh data.
- A fill past DEPTH, which separates dropped writes from wrapped ones.
- A frame restart with data left in the buffer and a byte written in the restart cycle.
- Bursts of 8 and 16 whose closing fill is below or above the threshold, which shows whether the request is evaluated again at burst end.
- A frame tail below the threshold, for the frame-done path.

A long random run then varies the write and read density, the envelope toggles, the error clears, the threshold, the burst length and the polarity. Every output is compared each cycle against a model built from the requirements. This exposes ordering, count, burst-counting and polarity faults that the directed cases do not combine.

// File: rtl/imgfifo_pkg.sv
package imgfifo_pkg;

    // Burst length in strobes for each select code
    function automatic logic [5:0] burst_len(input logic [1:0] sel);
        case (sel)
            2'd0:    return 6'd8;
            2'd1:    return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/imgfifo_store.sv
module imgfifo_store #(
    parameter int DEPTH = 2048,
    parameter int DW    = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_stb,
    input  logic             err_clr,
    output logic [DW-1:0]    rd_data,
    output logic [CNT_W-1:0] count,
    output logic             err
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [AW-1:0]    LAST_C  = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0]    rd_ptr;
        logic [AW-1:0]    wr_ptr;
        logic [CNT_W-1:0] count;
        logic [DW-1:0]    rd_data;
        logic             err;
    } store_t;

    store_t s_d, s_q;
    logic [DW-1:0] mem [DEPTH];
    logic          push;
    logic [AW-1:0] wr_idx;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == LAST_C) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        logic full, empty, do_rd, do_wr, new_err;
        s_d     = s_q;
        full    = (s_q.count == DEPTH_C);
        empty   = (s_q.count == '0);
        do_rd   = 1'b0;
        do_wr   = 1'b0;
        new_err = 1'b0;
        push    = 1'b0;
        wr_idx  = s_q.wr_ptr;
        if (frame_start) begin
            // new frame: drop old contents, keep a byte arriving now
            new_err    = !empty;
            wr_idx     = '0;
            push       = wr_en;
            s_d.rd_ptr = '0;
            s_d.wr_ptr = wr_en ? AW'(1) : '0;
            s_d.count  = wr_en ? CNT_W'(1) : '0;
        end else begin
            do_rd = rd_stb && !empty;
            do_wr = wr_en && !full;
            if (wr_en && full) new_err = 1'b1;
            if (do_rd) begin
                s_d.rd_data = mem[s_q.rd_ptr];
                s_d.rd_ptr  = nxt(s_q.rd_ptr);
            end
            if (do_wr) begin
                push       = 1'b1;
                s_d.wr_ptr = nxt(s_q.wr_ptr);
            end
            s_d.count = s_q.count + {{(CNT_W-1){1'b0}}, do_wr}
                                  - {{(CNT_W-1){1'b0}}, do_rd};
        end
        s_d.err = (s_q.err && !err_clr) || new_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_idx] <= wr_data;
    end

    assign rd_data = s_q.rd_data;
    assign count   = s_q.count;
    assign err     = s_q.err;

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= DEPTH_C);
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_stb && !frame_start && s_q.count == DEPTH_C)
        |=> (s_q.count == DEPTH_C && s_q.err));
    p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !frame_start && s_q.count == '0) |=> $stable(rd_data));
    p_frame_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> s_q.count <= CNT_W'(1));
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err && !err_clr) |=> s_q.err);
endmodule

// File: rtl/imgfifo_req.sv
module imgfifo_req #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_env,
    input  logic             rd_stb,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thresh,
    input  logic [1:0]       burst_sel,
    input  logic             drq_high,
    output logic             frame_start,
    output logic             irq,
    output logic             drq
);
    typedef struct packed {
        logic       env;
        logic       frame_done;
        logic       in_burst;
        logic [5:0] beat;
    } req_t;

    req_t r_d, r_q;
    logic avail, act, frame_end;
    logic [5:0] len;

    assign len         = imgfifo_pkg::burst_len(burst_sel);
    assign frame_start = frame_env && !r_q.env;
    assign frame_end   = !frame_env && r_q.env;
    assign avail       = (count >= thresh) || (r_q.frame_done && count != '0);
    assign act         = !r_q.in_burst && avail;

    always_comb begin
        r_d     = r_q;
        r_d.env = frame_env;
        if (frame_start) begin
            r_d.frame_done = 1'b0;
            r_d.in_burst   = 1'b0;
            r_d.beat       = '0;
        end else begin
            if (frame_end) r_d.frame_done = 1'b1;
            if (rd_stb) begin
                if (r_q.in_burst) begin
                    if (r_q.beat + 6'd1 >= len) begin
                        r_d.in_burst = 1'b0;
                        r_d.beat     = '0;
                    end else begin
                        r_d.beat = r_q.beat + 6'd1;
                    end
                end else if (act) begin
                    r_d.in_burst = 1'b1;
                    r_d.beat     = 6'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq = avail;
    assign drq = drq_high ? act : !act;

    p_burst_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && act && !frame_start) |=> r_q.in_burst);
    p_burst_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.in_burst |-> r_q.beat != '0);
    p_burst_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.in_burst && rd_stb && !frame_start && r_q.beat + 6'd1 >= len)
        |=> !r_q.in_burst);
    p_done_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !r_q.frame_done);
    p_done_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> r_q.frame_done);
endmodule

// File: rtl/img_host_fifo.sv
module img_host_fifo #(
    parameter int DEPTH = 2048,
    parameter int DW    = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_env,
    input  logic             px_valid,
    input  logic [DW-1:0]    px_data,
    input  logic             host_rd,
    input  logic             err_clr,
    input  logic [CNT_W-1:0] cfg_thresh,
    input  logic [1:0]       cfg_burst,
    input  logic             cfg_drq_high,
    output logic [DW-1:0]    rd_byte,
    output logic [CNT_W-1:0] fill_count,
    output logic             err_flag,
    output logic             irq,
    output logic             drq
);
    logic frame_start;

    imgfifo_store #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .wr_en       (px_valid && frame_env),
        .wr_data     (px_data),
        .rd_stb      (host_rd),
        .err_clr     (err_clr),
        .rd_data     (rd_byte),
        .count       (fill_count),
        .err         (err_flag)
    );

    imgfifo_req #(.CNT_W(CNT_W)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_env   (frame_env),
        .rd_stb      (host_rd),
        .count       (fill_count),
        .thresh      (cfg_thresh),
        .burst_sel   (cfg_burst),
        .drq_high    (cfg_drq_high),
        .frame_start (frame_start),
        .irq         (irq),
        .drq         (drq)
    );
endmodule

// File: tb/img_host_fifo_tb_top.sv
`timescale 1ns/1ps
module img_host_fifo_tb_top;
    localparam int DEPTH = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_env = 1'b0, px_valid = 1'b0, host_rd = 1'b0, err_clr = 1'b0;
    logic [7:0]  px_data = '0;
    logic [15:0] cfg_thresh = 16'd8;
    logic [1:0]  cfg_burst = 2'd0;
    logic        cfg_drq_high = 1'b1;
    logic [7:0]  rd_byte;
    logic [15:0] fill_count;
    logic        err_flag, irq, drq;

    int nchk = 0, nerr = 0;

    // requirement-level model state
    byte unsigned q[$];
    int  m_rd = 0, m_beat = 0;
    bit  m_err = 0, m_fd = 0, m_inb = 0, m_vp = 0;

    always #4 clk = ~clk;

    img_host_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .frame_env(frame_env), .px_valid(px_valid),
        .px_data(px_data), .host_rd(host_rd), .err_clr(err_clr),
        .cfg_thresh(cfg_thresh), .cfg_burst(cfg_burst), .cfg_drq_high(cfg_drq_high),
        .rd_byte(rd_byte), .fill_count(fill_count), .err_flag(err_flag),
        .irq(irq), .drq(drq)
    );

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int blen(logic [1:0] s);
        return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    endfunction

    function automatic bit exp_avail();
        return (q.size() >= int'(cfg_thresh)) || (m_fd && q.size() != 0);
    endfunction

    function automatic bit exp_drq();
        bit a;
        a = !m_inb && exp_avail();
        return cfg_drq_high ? a : !a;
    endfunction

    task automatic model_step();
        bit rise, fall, act, full, newe;
        rise = frame_env && !m_vp;
        fall = !frame_env && m_vp;
        act  = !m_inb && exp_avail();
        newe = 0;
        if (rise) begin
            if (q.size() != 0) newe = 1;
            q.delete();
            if (px_valid) q.push_back(px_data);
            m_inb = 0; m_beat = 0; m_fd = 0;
        end else begin
            full = (q.size() == DEPTH);
            if (host_rd) begin
                if (q.size() > 0) m_rd = q.pop_front();
                if (m_inb) begin
                    m_beat++;
                    if (m_beat >= blen(cfg_burst)) begin m_inb = 0; m_beat = 0; end
                end else if (act) begin
                    m_inb = 1; m_beat = 1;
                end
            end
            if (frame_env && px_valid) begin
                if (full) newe = 1;
                else q.push_back(px_data);
            end
            if (fall) m_fd = 1;
        end
        m_err = (m_err && !err_clr) || newe;
        m_vp  = frame_env;
    endtask

    task automatic compare_all();
        chk("R2 fill_count", fill_count, q.size());
        chk("R2/R4 rd_byte", rd_byte, m_rd);
        chk("R6 err_flag", err_flag, m_err);
        chk("R7/R11 irq", irq, exp_avail());
        chk("R8/R9/R10 drq", drq, exp_drq());
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        px_valid = 0; host_rd = 0; err_clr = 0;
    endtask

    task automatic wr_bytes(int n, int base);
        for (int i = 0; i < n; i++) begin
            px_valid = 1; px_data = 8'(base + i);
            cycle();
        end
    endtask

    task automatic rd_bytes(int n);
        for (int i = 0; i < n; i++) begin
            host_rd = 1;
            cycle();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", fill_count, 0);
        chk("R1 rd_byte", rd_byte, 0);
        chk("R1 err", err_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 drq", drq, 0);

        // R2 order, ignored writes outside envelope
        wr_bytes(3, 8'h50);
        chk("R2 write outside envelope ignored", fill_count, 0);
        frame_env = 1; cycle();
        wr_bytes(5, 8'hA0);
        rd_bytes(5);
        chk("R2 last byte in order", rd_byte, 8'hA4);

        // R4 empty reads hold last byte
        rd_bytes(2);
        chk("R4 empty read holds byte", rd_byte, 8'hA4);
        chk("R4 empty count", fill_count, 0);

        // R3 overflow
        cfg_thresh = 16'd2032;
        wr_bytes(DEPTH + 3, 0);
        chk("R3 count capped", fill_count, DEPTH);
        chk("R3 error on overflow", err_flag, 1);

        // R6 clear
        err_clr = 1; cycle();
        chk("R6 err cleared", err_flag, 0);

        // R5 frame restart with data left, byte in the restart cycle
        frame_env = 0; cycle();
        frame_env = 1; px_valid = 1; px_data = 8'h3C; cycle();
        chk("R5 count after restart", fill_count, 1);
        chk("R5 discard error", err_flag, 1);
        rd_bytes(1);
        chk("R5 first byte of frame", rd_byte, 8'h3C);
        err_clr = 1; cycle();

        // R8/R9 burst of 8, close below threshold
        cfg_thresh = 16'd8; cfg_burst = 2'd0;
        wr_bytes(8, 8'h10);
        chk("R8 drq raised at threshold", drq, 1);
        rd_bytes(1);
        chk("R8 drq drops after first read", drq, 0);
        rd_bytes(7);
        chk("R9 drq stays low below threshold", drq, 0);

        // R9 burst of 16, re-evaluated high at close
        cfg_thresh = 16'd16; cfg_burst = 2'd1;
        wr_bytes(40, 8'h20);
        rd_bytes(16);
        chk("R9 drq re-raised after burst", drq, 1);

        // R10 polarity
        cfg_drq_high = 0; cycle();
        chk("R10 active low drq", drq, 0);
        rd_bytes(1);
        chk("R10 active low idle", drq, 1);
        rd_bytes(15);
        cfg_drq_high = 1;
        rd_bytes(8);

        // R11 frame tail below threshold
        cfg_thresh = 16'd20; cfg_burst = 2'd0;
        wr_bytes(3, 8'h70);
        chk("R7 irq low below threshold", irq, 0);
        frame_env = 0; cycle();
        chk("R11 irq on frame tail", irq, 1);
        chk("R11 drq on frame tail", drq, 1);
        rd_bytes(8);
        chk("R11 tail drained irq low", irq, 0);
        frame_env = 1; cycle();
        chk("R11 frame done cleared", irq, 0);

        // random phase
        for (int i = 0; i < 20000; i++) begin
            if (i % 1000 == 0) begin
                cfg_thresh   = 16'($urandom % 48 + 1);
                cfg_burst    = 2'($urandom % 4);
                cfg_drq_high = 1'($urandom % 2);
            end
            if ($urandom % 300 == 0) frame_env = !frame_env;
            px_valid = ($urandom % 4) != 0;
            px_data  = 8'($urandom);
            host_rd  = ($urandom % 3) == 0;
            err_clr  = ($urandom % 100) == 0;
            cycle();
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule